// File: doc/BRIEF.md
# Block Affine Map Engine

This block applies an affine map, y = 3·x − 4, to a block of signed 32-bit words held in external memory. A host sends a five-beat command on a 32-bit valid/ready stream. The command gives the element count, the byte address of the source block and the byte address of the destination block. The engine works in strict phases:

- It reads every source word into a local buffer.
- It transforms the buffer in place, one element per cycle.
- It writes the results back to consecutive destination words.
- It pulses `done`.

The command stream carries no reply. The host learns of completion from `done` and then reads the results from memory.

The memory side is a single-word request channel: valid/ready, a write-enable, a 64-bit byte address and write data. Read data comes back in request order on a separate valid strobe and may arrive any number of cycles later. Scale, bias, widths and buffer depth are parameters. The defaults are scale 3, bias −4, a 32-bit stream and data word, 64-bit addresses and a 256-entry buffer.

Top module: `affine_block_engine`

## Requirements
- R1: A command is five accepted stream beats (valid and ready both high at a clock edge), in this order: element count n (unsigned), source address bits 31:0, source address bits 63:32, destination address bits 31:0, destination address bits 63:32. Idle cycles between beats are allowed.
- R2: `cmd_ready` is high whenever the engine is idle. It is low from the cycle after the fifth beat is accepted through the cycle in which `done` is high, and it is high again in the cycle after that.
- R3: For a command with effective length m, the engine issues exactly m read requests (`mem_req_we` = 0), at source + 4·i for i = 0 … m−1 in increasing order. It issues them before any write request.
- R4: Each result is the low 32 bits of 3·x − 4 in two's complement, so overflow wraps.
- R5: Write requests (`mem_req_we` = 1) go to destination + 4·i for i = 0 … m−1 in increasing order, with the result for element i. None is issued until all m read data words have returned.
- R6: A count n greater than 256 is treated as m = 256. No word past element m−1 is read or written in either region.
- R7: A command with n = 0 issues no memory request, and `done` is high in the cycle right after the fifth beat is accepted.
- R8: `done` is high for exactly one cycle per command, in the cycle after the last write request is accepted.
- R9: `mem_rd_valid` pulses while the engine is idle are ignored and do not change later results.
- R10: A memory request that is not accepted stays valid, with address, write-enable and write data unchanged, until it is accepted.
- R11: After reset, `cmd_ready` = 1, `mem_req_valid` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command beat offered |
| cmd_ready | output | 1 | Engine accepts a command beat |
| cmd_data | input | 32 | Command beat payload |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rd_valid | input | 1 | Read data word returned |
| mem_rd_data | input | 32 | Returned read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases:

- **Wrapping arithmetic.** Operands at the signed extremes would show a design that saturates or sign-extends in the wrong way.
- **Count of 300.** A design that fails to clamp would read past element 255 and overwrite a sentinel word behind the destination block.
- **Count of zero.** A design that enters the load phase anyway would issue a stray request or report `done` late.
- **Stalls and slow read returns.** Stalled request acceptance and read data arriving several cycles late expose a design that drops a held request, advances its address early, or starts writing before the last operand has arrived.
- **Stray read strobes.** Read strobes sent while idle would corrupt the buffer of a design that does not gate them.
- **Back-to-back commands.** A second command sent right after `done` checks that `cmd_ready` returns on time.

// File: rtl/affine_pkg.sv
package affine_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LOAD  = 3'd1,
      PH_COMP  = 3'd2,
      PH_STORE = 3'd3,
      PH_DONE  = 3'd4
   } phase_e;

   // one length beat plus two address fields, each split into stream words
   function automatic int beats_per_cmd(int addr_w, int cmd_w);
      return 1 + 2 * (addr_w / cmd_w);
   endfunction

endpackage

// File: rtl/affine_cmd_rx.sv
module affine_cmd_rx #(
   parameter int CMD_W  = 32,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_en,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_data,
   output logic              cmd_ready,
   output logic              cmd_fire,
   output logic [CMD_W-1:0]  cmd_len,
   output logic [ADDR_W-1:0] cmd_src,
   output logic [ADDR_W-1:0] cmd_dst
);
   localparam int WPA    = ADDR_W / CMD_W;
   localparam int NBEAT  = affine_pkg::beats_per_cmd(ADDR_W, CMD_W);
   localparam int LAST   = NBEAT - 1;
   localparam int BEAT_W = $clog2(NBEAT);

   if ((ADDR_W % CMD_W) != 0) begin : g_bad_split
      $error("affine_cmd_rx: ADDR_W must be a multiple of CMD_W");
   end

   logic [BEAT_W-1:0] beat_q;
   logic              take;
   logic              last_beat;

   assign cmd_ready = accept_en;
   assign take      = cmd_valid & accept_en;
   assign last_beat = (beat_q == BEAT_W'(LAST));
   assign cmd_fire  = take & last_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    beat_q <= '0;
      else if (take) beat_q <= last_beat ? '0 : beat_q + 1'b1;
   end

   // every beat except the final one is held; the final beat is used live
   for (genvar g = 0; g < LAST; g++) begin : g_word
      logic [CMD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= '0;
         else if (take && (beat_q == BEAT_W'(g)))     q <= cmd_data;
      end
   end

   assign cmd_len = g_word[0].q;

   for (genvar w = 0; w < WPA; w++) begin : g_src
      assign cmd_src[w*CMD_W +: CMD_W] = g_word[1 + w].q;
   end

   for (genvar w = 0; w < WPA; w++) begin : g_dst
      if ((1 + WPA + w) == LAST) begin : g_live
         assign cmd_dst[w*CMD_W +: CMD_W] = cmd_data;
      end else begin : g_held
         assign cmd_dst[w*CMD_W +: CMD_W] = g_word[1 + WPA + w].q;
      end
   end

endmodule

// File: rtl/affine_elem_buf.sv
module affine_elem_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("affine_elem_buf: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cell_q[wr_idx] <= wr_data;
   end

   assign rd_data = cell_q[rd_idx];

endmodule

// File: rtl/affine_lane.sv
module affine_lane #(
   parameter int DATA_W = 32,
   parameter int SCALE  = 3,
   parameter int BIAS   = -4
) (
   input  logic [DATA_W-1:0] x_in,
   output logic [DATA_W-1:0] y_out
);
   localparam logic [DATA_W-1:0] SCALE_V = DATA_W'(SCALE);
   localparam logic [DATA_W-1:0] BIAS_V  = DATA_W'(BIAS);
   localparam bit IS_POW2 = (SCALE > 0) && ((SCALE & (SCALE - 1)) == 0);

   logic [DATA_W-1:0] scaled;

   // low DATA_W bits of a product are the same for signed and unsigned views
   if (SCALE == 1) begin : g_unit
      assign scaled = x_in;
   end else if (IS_POW2) begin : g_shift
      assign scaled = x_in << $clog2(SCALE);
   end else begin : g_mul
      assign scaled = x_in * SCALE_V;
   end

   assign y_out = scaled + BIAS_V;

endmodule

// File: rtl/affine_seq.sv
module affine_seq
   import affine_pkg::*;
#(
   parameter int CMD_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 64,
   parameter int MAX_LEN = 256,
   localparam int IDX_W  = $clog2(MAX_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_fire,
   input  logic [CMD_W-1:0]  cmd_len,
   input  logic [ADDR_W-1:0] cmd_src,
   input  logic [ADDR_W-1:0] cmd_dst,
   output logic              accept_en,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              buf_wr_en,
   output logic [IDX_W-1:0]  buf_wr_idx,
   output logic [DATA_W-1:0] buf_wr_data,
   output logic [IDX_W-1:0]  buf_rd_idx,
   input  logic [DATA_W-1:0] buf_rd_data,
   input  logic [DATA_W-1:0] lane_y,
   output logic              done
);
   localparam int LEN_W   = $clog2(MAX_LEN + 1);
   localparam int BYTE_SH = $clog2(DATA_W / 8);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

   phase_e            phase_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  req_idx_q;
   logic [LEN_W-1:0]  rsp_idx_q;
   logic [LEN_W-1:0]  cmp_idx_q;
   logic [LEN_W-1:0]  len_cap;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic              req_fire;
   logic              rd_take;
   logic              req_last;
   logic              rsp_last;
   logic              cmp_last;
   logic              in_load;
   logic              in_store;

   always_comb begin
      if (cmd_len > CMD_W'(MAX_LEN)) len_cap = CAP;
      else                           len_cap = cmd_len[LEN_W-1:0];
   end

   assign in_load   = (phase_q == PH_LOAD);
   assign in_store  = (phase_q == PH_STORE);
   assign accept_en = (phase_q == PH_IDLE);
   assign done      = (phase_q == PH_DONE);

   assign mem_req_valid = (in_load || in_store) && (req_idx_q < len_q);
   assign mem_req_we    = in_store;
   assign mem_req_addr  = (in_store ? dst_q : src_q) + (ADDR_W'(req_idx_q) << BYTE_SH);
   assign mem_req_wdata = in_store ? buf_rd_data : '0;
   assign buf_rd_idx    = in_store ? req_idx_q[IDX_W-1:0] : cmp_idx_q[IDX_W-1:0];

   assign req_fire = mem_req_valid & mem_req_ready;
   assign rd_take  = in_load & mem_rd_valid;
   assign req_last = (req_idx_q == len_q - 1'b1);
   assign rsp_last = (rsp_idx_q == len_q - 1'b1);
   assign cmp_last = (cmp_idx_q == len_q - 1'b1);

   always_comb begin
      buf_wr_en   = 1'b0;
      buf_wr_idx  = rsp_idx_q[IDX_W-1:0];
      buf_wr_data = mem_rd_data;
      if (rd_take) begin
         buf_wr_en = 1'b1;
      end else if (phase_q == PH_COMP) begin
         buf_wr_en   = 1'b1;
         buf_wr_idx  = cmp_idx_q[IDX_W-1:0];
         buf_wr_data = lane_y;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         len_q     <= '0;
         src_q     <= '0;
         dst_q     <= '0;
         req_idx_q <= '0;
         rsp_idx_q <= '0;
         cmp_idx_q <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (cmd_fire) begin
                  len_q     <= len_cap;
                  src_q     <= cmd_src;
                  dst_q     <= cmd_dst;
                  req_idx_q <= '0;
                  rsp_idx_q <= '0;
                  cmp_idx_q <= '0;
                  phase_q   <= (len_cap == '0) ? PH_DONE : PH_LOAD;
               end
            end
            PH_LOAD: begin
               if (req_fire) req_idx_q <= req_idx_q + 1'b1;
               if (rd_take) begin
                  rsp_idx_q <= rsp_idx_q + 1'b1;
                  if (rsp_last) phase_q <= PH_COMP;
               end
            end
            PH_COMP: begin
               cmp_idx_q <= cmp_idx_q + 1'b1;
               if (cmp_last) begin
                  phase_q   <= PH_STORE;
                  req_idx_q <= '0;
               end
            end
            PH_STORE: begin
               if (req_fire) begin
                  req_idx_q <= req_idx_q + 1'b1;
                  if (req_last) phase_q <= PH_DONE;
               end
            end
            PH_DONE:  phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_we) && $stable(mem_req_wdata))); // R10

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (in_load && mem_rd_valid) |-> (rsp_idx_q < req_idx_q)); // R3

   AST_WR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we) |-> (rsp_idx_q == len_q)); // R5

   AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && (cmd_len > CMD_W'(MAX_LEN))) |=> (len_q == CAP)); // R6

endmodule

// File: rtl/affine_block_engine.sv
module affine_block_engine #(
   parameter int CMD_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 64,
   parameter int MAX_LEN = 256,
   parameter int SCALE   = 3,
   parameter int BIAS    = -4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [CMD_W-1:0]  cmd_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              done
);
   localparam int IDX_W = $clog2(MAX_LEN);
   localparam int LEN_W = $clog2(MAX_LEN + 1);

   if ((DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("affine_block_engine: DATA_W must be a power-of-two byte multiple");
   end
   if (MAX_LEN < 2) begin : g_bad_len
      $error("affine_block_engine: MAX_LEN must be at least 2");
   end
   if (CMD_W < LEN_W) begin : g_bad_cmd
      $error("affine_block_engine: CMD_W too narrow for the length field");
   end

   logic              accept_en;
   logic              cmd_fire;
   logic [CMD_W-1:0]  cmd_len;
   logic [ADDR_W-1:0] cmd_src;
   logic [ADDR_W-1:0] cmd_dst;
   logic              buf_wr_en;
   logic [IDX_W-1:0]  buf_wr_idx;
   logic [DATA_W-1:0] buf_wr_data;
   logic [IDX_W-1:0]  buf_rd_idx;
   logic [DATA_W-1:0] buf_rd_data;
   logic [DATA_W-1:0] lane_y;

   affine_cmd_rx #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_en (accept_en),
      .cmd_valid (cmd_valid),
      .cmd_data  (cmd_data),
      .cmd_ready (cmd_ready),
      .cmd_fire  (cmd_fire),
      .cmd_len   (cmd_len),
      .cmd_src   (cmd_src),
      .cmd_dst   (cmd_dst)
   );

   affine_seq #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_fire      (cmd_fire),
      .cmd_len       (cmd_len),
      .cmd_src       (cmd_src),
      .cmd_dst       (cmd_dst),
      .accept_en     (accept_en),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_we    (mem_req_we),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_data   (mem_rd_data),
      .buf_wr_en     (buf_wr_en),
      .buf_wr_idx    (buf_wr_idx),
      .buf_wr_data   (buf_wr_data),
      .buf_rd_idx    (buf_rd_idx),
      .buf_rd_data   (buf_rd_data),
      .lane_y        (lane_y),
      .done          (done)
   );

   affine_elem_buf #(.DATA_W(DATA_W), .DEPTH(MAX_LEN)) u_buf (
      .clk     (clk),
      .wr_en   (buf_wr_en),
      .wr_idx  (buf_wr_idx),
      .wr_data (buf_wr_data),
      .rd_idx  (buf_rd_idx),
      .rd_data (buf_rd_data)
   );

   affine_lane #(.DATA_W(DATA_W), .SCALE(SCALE), .BIAS(BIAS)) u_lane (
      .x_in  (buf_rd_data),
      .y_out (lane_y)
   );

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fire |=> !cmd_ready); // R2

   AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && (cmd_len == '0)) |=> (done && !mem_req_valid)); // R7

endmodule

// File: tb/affine_block_engine_tb.sv
module affine_block_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam longint NEVER = 64'sh3fff_ffff_ffff_ffff;
   localparam longint WDOG_LIMIT = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_data = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic        mem_req_we;
   logic [63:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        done;

   affine_block_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .done(done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit run_over = 1'b0;

   // behavioural memory and reference expectations
   logic [31:0] mem [longint unsigned];
   logic [63:0] exp_addr_q [$];
   bit          exp_we_q [$];
   logic [31:0] exp_wd_q [$];
   logic [31:0] rsp_data_q [$];
   longint      rsp_due_q [$];
   longint      done_due = -1;
   int          lat = 1;
   bit          stall_mode = 1'b0;
   bit          junk_en = 1'b0;
   bit          prev_stall = 1'b0;
   logic [63:0] prev_addr;
   logic        prev_we;
   logic [31:0] prev_wd;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(logic [63:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   function automatic logic [31:0] affine(logic [31:0] x);
      int xi;
      xi = int'(x);
      return 32'(3 * xi - 4);
   endfunction

   // per-clock reference comparison
   initial begin : p_mem
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         mem_req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
         if (rsp_due_q.size() > 0 && rsp_due_q[0] <= cyc) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = rsp_data_q.pop_front();
            void'(rsp_due_q.pop_front());
         end else if (junk_en) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = 32'hDEAD_BEEF;
         end else begin
            mem_rd_valid = 1'b0;
            mem_rd_data  = '0;
         end
         #1;
         chk(cmd_ready == (cyc > done_due), "R2", "cmd_ready", longint'(cmd_ready), longint'(cyc > done_due));
         chk(done == (cyc == done_due), "R8", "done", longint'(done), longint'(cyc == done_due));
         if (prev_stall) begin
            chk(mem_req_valid && mem_req_addr == prev_addr && mem_req_we == prev_we
                && mem_req_wdata == prev_wd, "R10", "held request", longint'(mem_req_addr), longint'(prev_addr));
         end
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         prev_we    = mem_req_we;
         prev_wd    = mem_req_wdata;
         if (mem_req_valid) begin
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected request", longint'(mem_req_addr), 0);
            end else if (mem_req_ready) begin
               if (!exp_we_q[0]) begin
                  chk(!mem_req_we && mem_req_addr == exp_addr_q[0], "R3", "read address",
                      longint'(mem_req_addr), longint'(exp_addr_q[0]));
                  rsp_data_q.push_back(rd(mem_req_addr));
                  rsp_due_q.push_back(cyc + lat);
               end else begin
                  chk(mem_req_we && mem_req_addr == exp_addr_q[0], "R5", "write address",
                      longint'(mem_req_addr), longint'(exp_addr_q[0]));
                  chk(mem_req_wdata == exp_wd_q[0], "R4", "write data",
                      longint'(mem_req_wdata), longint'(exp_wd_q[0]));
                  chk(rsp_data_q.size() == 0, "R5", "write before reads returned",
                      longint'(rsp_data_q.size()), 0);
                  mem[mem_req_addr] = mem_req_wdata;
               end
               void'(exp_addr_q.pop_front());
               void'(exp_we_q.pop_front());
               void'(exp_wd_q.pop_front());
               if (mem_req_we && exp_addr_q.size() == 0) done_due = cyc + 1;
            end
         end
      end
   end

   task automatic send_cmd(int unsigned n, logic [63:0] xb, logic [63:0] yb, int gap, output longint c5);
      logic [31:0] beats [5];
      int m;
      beats[0] = n;
      beats[1] = xb[31:0];
      beats[2] = xb[63:32];
      beats[3] = yb[31:0];
      beats[4] = yb[63:32];
      m = (n > 256) ? 256 : int'(n);
      c5 = 0;
      for (int b = 0; b < 5; b++) begin
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
         end
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_data  = beats[b];
         #2;
         while (!cmd_ready) begin
            @(negedge clk);
            #2;
         end
         if (b == 4) begin
            c5 = cyc;
            for (int i = 0; i < m; i++) begin
               exp_addr_q.push_back(xb + 64'(4 * i));
               exp_we_q.push_back(1'b0);
               exp_wd_q.push_back('0);
            end
            for (int i = 0; i < m; i++) begin
               exp_addr_q.push_back(yb + 64'(4 * i));
               exp_we_q.push_back(1'b1);
               exp_wd_q.push_back(affine(rd(xb + 64'(4 * i))));
            end
            done_due = (m == 0) ? cyc + 1 : NEVER;
         end
      end
   endtask

   task automatic wait_done(output longint seen);
      forever begin
         @(negedge clk);
         cmd_valid = 1'b1;          // offered while busy: must not be taken
         cmd_data  = 32'hBAD0_BAD0;
         #2;
         if (done) begin
            cmd_valid = 1'b0;
            seen = cyc;
            break;
         end
      end
   endtask

   task automatic verify(int m, logic [63:0] xb, logic [63:0] yb, string tag);
      for (int i = 0; i < m; i++) begin
         chk(rd(yb + 64'(4 * i)) == affine(rd(xb + 64'(4 * i))), tag, "stored result",
             longint'(rd(yb + 64'(4 * i))), longint'(affine(rd(xb + 64'(4 * i)))));
      end
      chk(rd(yb + 64'(4 * m)) == 32'h5A5A_5A5A, "R6", "word past block untouched",
          longint'(rd(yb + 64'(4 * m))), 32'h5A5A_5A5A);
      chk(exp_addr_q.size() == 0, "R3", "requests outstanding", longint'(exp_addr_q.size()), 0);
   endtask

   task automatic run_case(int unsigned n, logic [63:0] xb, logic [63:0] yb, int gap, string tag);
      longint c5;
      longint seen;
      int m;
      m = (n > 256) ? 256 : int'(n);
      mem[yb + 64'(4 * m)] = 32'h5A5A_5A5A;
      send_cmd(n, xb, yb, gap, c5);
      wait_done(seen);
      if (n == 0) chk(seen == c5 + 1, "R7", "zero-length done cycle", seen, c5 + 1);
      verify(m, xb, yb, tag);
   endtask

   task automatic finish_run();
      run_over = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin : p_wdog
      while (cyc < WDOG_LIMIT) @(posedge clk);
      if (!run_over) begin
         chk(1'b0, "WDOG", "watchdog expired", cyc, WDOG_LIMIT);
         finish_run();
      end
   end

   initial begin : p_main
      logic [63:0] xb;
      logic [63:0] yb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R11 reset state
      chk(cmd_ready == 1'b1, "R11", "cmd_ready after reset", longint'(cmd_ready), 1);
      chk(mem_req_valid == 1'b0, "R11", "mem_req_valid after reset", longint'(mem_req_valid), 0);
      chk(done == 1'b0, "R11", "done after reset", longint'(done), 0);

      // R9: stray read strobes while idle, then extreme operands (R4 wrap)
      junk_en = 1'b1;
      repeat (6) @(negedge clk);
      junk_en = 1'b0;
      xb = 64'h0000_0001_0000_1000;
      yb = 64'h0000_0002_0000_2000;
      mem[xb]      = 32'h7FFF_FFFF;
      mem[xb + 4]  = 32'h8000_0000;
      mem[xb + 8]  = 32'hFFFF_FFFF;
      mem[xb + 12] = 32'h0000_0005;
      lat = 1;
      stall_mode = 1'b0;
      run_case(4, xb, yb, 0, "R9");

      // R1: gapped beats, stalls and slow returns
      xb = 64'h0000_0003_0000_0100;
      yb = 64'h0000_0004_0000_0400;
      for (int i = 0; i < 16; i++) mem[xb + 64'(4 * i)] = 32'(i * 123457 - 900000);
      lat = 3;
      stall_mode = 1'b1;
      run_case(16, xb, yb, 2, "R1");

      // R7: zero length
      run_case(0, 64'h0000_0005_0000_0000, 64'h0000_0006_0000_0000, 1, "R7");

      // R6: oversized count is clamped
      xb = 64'h0000_0007_0001_0000;
      yb = 64'h0000_0008_0002_0000;
      for (int i = 0; i < 300; i++) mem[xb + 64'(4 * i)] = 32'(i * 37 - 500);
      lat = 2;
      run_case(300, xb, yb, 0, "R6");

      // R2: back-to-back command right after done
      xb = 64'h0000_0009_0000_0040;
      yb = 64'h0000_000A_0000_0080;
      mem[xb] = 32'h1234_5678;
      lat = 1;
      stall_mode = 1'b0;
      run_case(1, xb, yb, 0, "R4");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule